// File: doc/BRIEF.md
# Fault-Driven Refill Way Selector

This block supports software refill of a set-associative translation buffer. It keeps a 16-bit pseudo-random shift register. The register advances only when a translation fault is signalled, never on a hit. When a fault arrives, the block works out which buffer entry software should overwrite, written as an index plus a way, and puts it in a select register value. It also captures a cause register value that describes the fault: the faulting virtual page, the kind of access and the current process ID.

On a plain miss the way comes from the random register, so that refills spread across the ways. On a protection fault the translation did hit, so the way that hit is reported instead. Writing the buffer entry itself is left to the software that reads these two values.

Top module: `refill_way_picker`

## Requirements
- R1: After reset `tlbSel` and `causeReg` are all zeros and the random register holds 0xCCCC, so the first miss after reset reports way 0.
- R2: The bit shifted in is the XOR of the register bits at positions 15, 11, 2 and 0 (tap mask 0x8805).
- R3: In each cycle with `faultStb` high, the register shifts right by one position and the feedback bit enters at bit 15. The width stays 16 bits.
- R4: On a miss (`faultStb` high, `faultIsMiss` high), the way reported is register bits [1:0] as they stood before that shift.
- R5: On a protection fault (`faultStb` high, `faultIsMiss` low), the way reported is `hitWay`, and the random register still advances.
- R6: On any fault, `tlbSel` is rebuilt from zero: bits [3:0] take `vpage[3:0]`, bits [5:4] take the chosen way, and bits [31:6] are zero.
- R7: On any fault, `causeReg` bits [31:13] take `vpage`, bits [9:8] take `accType` and bits [7:0] take `pid`. Bits [12:10] keep their previous value, which is zero from reset.
- R8: In cycles with `faultStb` low, `tlbSel`, `causeReg` and the random register keep their values, whatever the other inputs do.
- R9: Access codes are read = 2'b00, write = 2'b01 and execute = 2'b10. Each is stored unchanged in `causeReg[9:8]`.
- R10: Starting from the seed, the register never becomes all zeros. Over at least 1000 consecutive faults, the reported miss ways follow the sequence given by R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| faultStb | input | 1 | One-cycle strobe per translation fault |
| faultIsMiss | input | 1 | 1 = no entry matched; 0 = an entry hit but access was refused |
| hitWay | input | 2 | Way that matched, used on protection faults |
| vpage | input | 19 | Virtual page number of the faulting access |
| accType | input | 2 | Access code: 00 read, 01 write, 10 execute |
| pid | input | 8 | Current process ID |
| tlbSel | output | 32 | Select register value: way and index to refill |
| causeReg | output | 32 | Cause register value: page, access code, PID |

## Verification
The assertions assume that `accType` never carries the unused code 2'b11. They also assume that `hitWay` and `faultIsMiss` are only meaningful while `faultStb` is high. The bench therefore drives only the three defined codes. It changes `hitWay`, `vpage` and `pid` freely in idle cycles, to show that these inputs have no effect there. Faults are issued as single-cycle strobes, either isolated or back to back. This lets each register update be tied to exactly one clock edge.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10
  } acc_e;

  typedef struct packed {
    logic advance;
    logic capture;
    logic takeHitWay;
  } rwp_stb_t;
endpackage

// File: rtl/rwp_lfsr.sv
module rwp_lfsr #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hCCCC,
  parameter logic [LFSR_W-1:0] TAPS = 16'h8805
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] stateQ;
  logic [LFSR_W-1:0] tapBits;
  logic              feedback;

  // one AND per position; unused taps reduce to constant zero
  for (genvar i = 0; i < LFSR_W; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapBits[i] = stateQ[i];
    end else begin : g_off
      assign tapBits[i] = 1'b0;
    end
  end

  assign feedback = ^tapBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEED;
    end else if (advance) begin
      stateQ <= {feedback, stateQ[LFSR_W-1:1]};
    end
  end

  assign state = stateQ;
endmodule

// File: rtl/rwp_ctrl.sv
module rwp_ctrl (
  input  logic              faultStb,
  input  logic              faultIsMiss,
  output rwp_pkg::rwp_stb_t stb
);
  always_comb begin
    stb = '0;
    if (faultStb) begin
      stb.advance    = 1'b1;
      stb.capture    = 1'b1;
      stb.takeHitWay = !faultIsMiss;
    end
  end
endmodule

// File: rtl/rwp_datapath.sv
module rwp_datapath #(
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hCCCC,
  parameter logic [LFSR_W-1:0] TAPS = 16'h8805,
  parameter int IDX_W   = 4,
  parameter int WAY_W   = 2,
  parameter int VPN_W   = 19,
  parameter int ACC_W   = 2,
  parameter int PID_W   = 8,
  parameter int SEL_W   = 32,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  rwp_pkg::rwp_stb_t  stb,
  input  logic [WAY_W-1:0]   hitWay,
  input  logic [VPN_W-1:0]   vpage,
  input  logic [ACC_W-1:0]   accType,
  input  logic [PID_W-1:0]   pid,
  output logic [SEL_W-1:0]   tlbSel,
  output logic [CAUSE_W-1:0] causeReg,
  output logic [LFSR_W-1:0]  lfsrState
);
  localparam int ACC_LSB = PID_W;
  localparam int VPN_LSB = CAUSE_W - VPN_W;
  localparam int WAY_LSB = IDX_W;

  logic [WAY_W-1:0]   wayPick;
  logic [SEL_W-1:0]   selNext, selQ;
  logic [CAUSE_W-1:0] causeNext, causeQ;

  rwp_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) lfsr_i (
    .clk     (clk),
    .rstN    (rstN),
    .advance (stb.advance),
    .state   (lfsrState)
  );

  assign wayPick = stb.takeHitWay ? hitWay : lfsrState[WAY_W-1:0];

  always_comb begin
    selNext = '0;
    selNext[IDX_W-1:0]       = vpage[IDX_W-1:0];
    selNext[WAY_LSB +: WAY_W] = wayPick;
  end

  always_comb begin
    causeNext = causeQ;
    causeNext[PID_W-1:0]       = pid;
    causeNext[ACC_LSB +: ACC_W] = accType;
    causeNext[VPN_LSB +: VPN_W] = vpage;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      causeQ <= '0;
    end else if (stb.capture) begin
      selQ   <= selNext;
      causeQ <= causeNext;
    end
  end

  assign tlbSel   = selQ;
  assign causeReg = causeQ;
endmodule

// File: rtl/refill_way_picker.sv
module refill_way_picker #(
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hCCCC,
  parameter logic [LFSR_W-1:0] TAPS = 16'h8805,
  parameter int IDX_W   = 4,
  parameter int WAY_W   = 2,
  parameter int VPN_W   = 19,
  parameter int ACC_W   = 2,
  parameter int PID_W   = 8,
  parameter int SEL_W   = 32,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               faultStb,
  input  logic               faultIsMiss,
  input  logic [WAY_W-1:0]   hitWay,
  input  logic [VPN_W-1:0]   vpage,
  input  logic [ACC_W-1:0]   accType,
  input  logic [PID_W-1:0]   pid,
  output logic [SEL_W-1:0]   tlbSel,
  output logic [CAUSE_W-1:0] causeReg
);
  rwp_pkg::rwp_stb_t stb;
  logic [LFSR_W-1:0] lfsrState;

  rwp_ctrl ctrl_i (
    .faultStb    (faultStb),
    .faultIsMiss (faultIsMiss),
    .stb         (stb)
  );

  rwp_datapath #(
    .LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .IDX_W(IDX_W), .WAY_W(WAY_W),
    .VPN_W(VPN_W), .ACC_W(ACC_W), .PID_W(PID_W), .SEL_W(SEL_W), .CAUSE_W(CAUSE_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hitWay    (hitWay),
    .vpage     (vpage),
    .accType   (accType),
    .pid       (pid),
    .tlbSel    (tlbSel),
    .causeReg  (causeReg),
    .lfsrState (lfsrState)
  );
endmodule

// File: rtl/rwp_checker.sv
module rwp_checker #(
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hCCCC,
  parameter logic [LFSR_W-1:0] TAPS = 16'h8805,
  parameter int IDX_W   = 4,
  parameter int WAY_W   = 2,
  parameter int VPN_W   = 19,
  parameter int ACC_W   = 2,
  parameter int PID_W   = 8,
  parameter int SEL_W   = 32,
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               faultStb,
  input logic               faultIsMiss,
  input logic [WAY_W-1:0]   hitWay,
  input logic [VPN_W-1:0]   vpage,
  input logic [ACC_W-1:0]   accType,
  input logic [PID_W-1:0]   pid,
  input logic [SEL_W-1:0]   tlbSel,
  input logic [CAUSE_W-1:0] causeReg,
  input logic [LFSR_W-1:0]  lfsrState
);
  localparam int VPN_LSB = CAUSE_W - VPN_W;
  localparam int ACC_LSB = PID_W;
  localparam int RSV_W   = VPN_LSB - (ACC_LSB + ACC_W);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (lfsrState == SEED && tlbSel == '0 && causeReg == '0));

  p_feedback_r2: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> lfsrState[LFSR_W-1] == ^($past(lfsrState) & TAPS));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> lfsrState[LFSR_W-2:0] == $past(lfsrState[LFSR_W-1:1]));

  p_miss_way_r4: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && faultIsMiss) |=>
      tlbSel[IDX_W +: WAY_W] == $past(lfsrState[WAY_W-1:0]));

  p_hit_way_r5: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && !faultIsMiss) |=> tlbSel[IDX_W +: WAY_W] == $past(hitWay));

  p_sel_layout_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> (tlbSel[IDX_W-1:0] == $past(vpage[IDX_W-1:0]) &&
                  tlbSel[SEL_W-1:IDX_W+WAY_W] == '0));

  p_cause_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> (causeReg[VPN_LSB +: VPN_W] == $past(vpage) &&
                  causeReg[PID_W-1:0] == $past(pid) &&
                  causeReg[ACC_LSB+ACC_W +: RSV_W] ==
                    $past(causeReg[ACC_LSB+ACC_W +: RSV_W])));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !faultStb |=> ($stable(tlbSel) && $stable(causeReg) && $stable(lfsrState)));

  p_acc_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultStb |=> causeReg[ACC_LSB +: ACC_W] == $past(accType));

  p_never_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);
endmodule

bind refill_way_picker rwp_checker #(
  .LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .IDX_W(IDX_W), .WAY_W(WAY_W),
  .VPN_W(VPN_W), .ACC_W(ACC_W), .PID_W(PID_W), .SEL_W(SEL_W), .CAUSE_W(CAUSE_W)
) chk_i (
  .clk(clk), .rstN(rstN), .faultStb(faultStb), .faultIsMiss(faultIsMiss),
  .hitWay(hitWay), .vpage(vpage), .accType(accType), .pid(pid),
  .tlbSel(tlbSel), .causeReg(causeReg), .lfsrState(lfsrState)
);

// File: tb/refill_way_picker_tb_top.sv
module refill_way_picker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultStb = 1'b0;
  logic        faultIsMiss = 1'b0;
  logic [1:0]  hitWay = '0;
  logic [18:0] vpage = '0;
  logic [1:0]  accType = '0;
  logic [7:0]  pid = '0;
  logic [31:0] tlbSel, causeReg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] refLfsr;

  always #10 clk = ~clk;

  refill_way_picker dut_i (
    .clk(clk), .rstN(rstN), .faultStb(faultStb), .faultIsMiss(faultIsMiss),
    .hitWay(hitWay), .vpage(vpage), .accType(accType), .pid(pid),
    .tlbSel(tlbSel), .causeReg(causeReg)
  );

  function automatic logic [15:0] stepRef(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[11] ^ s[2] ^ s[0];
    return {fb, s[15:1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one fault strobe, results checked one cycle later at the falling edge
  task automatic doFault(input logic miss, input logic [1:0] hw, input logic [18:0] vp,
                         input logic [1:0] acc, input logic [7:0] p, input string req);
    logic [1:0]  expWay;
    logic [31:0] prevCause;
    prevCause = causeReg;
    expWay = miss ? refLfsr[1:0] : hw;
    @(negedge clk);
    faultStb = 1'b1; faultIsMiss = miss; hitWay = hw; vpage = vp; accType = acc; pid = p;
    @(negedge clk);
    faultStb = 1'b0;
    refLfsr = stepRef(refLfsr);
    chk({req, " R6 sel"}, tlbSel, {26'd0, expWay, vp[3:0]});
    chk({req, " R7 cause"}, causeReg, {vp, prevCause[12:10], acc, p});
  endtask

  task automatic t_reset();
    chk("R1 sel reset", tlbSel, 32'h0);
    chk("R1 cause reset", causeReg, 32'h0);
    doFault(1'b1, 2'd3, 19'h00005, 2'b00, 8'h11, "R1 first miss way");
    chk("R1 seed low bits give way 0", {30'd0, tlbSel[5:4]}, 32'd0);
  endtask

  task automatic t_miss_patterns();
    doFault(1'b1, 2'd1, 19'h7FFFF, 2'b01, 8'hFF, "R4 miss all ones");
    doFault(1'b1, 2'd0, 19'h2A5A3, 2'b10, 8'h5A, "R4 miss mixed");
    doFault(1'b1, 2'd2, 19'h00000, 2'b00, 8'h00, "R4 miss zeros");
  endtask

  task automatic t_prot_fault();
    doFault(1'b0, 2'd3, 19'h1234C, 2'b01, 8'h42, "R5 prot way3");
    doFault(1'b0, 2'd1, 19'h0F00F, 2'b10, 8'h07, "R5 prot way1");
    // the next miss proves the register advanced on the protection faults
    doFault(1'b1, 2'd0, 19'h00AB1, 2'b00, 8'h09, "R5 R3 advance after prot");
  endtask

  task automatic t_idle_hold();
    logic [31:0] s0, c0;
    s0 = tlbSel; c0 = causeReg;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      faultIsMiss = i[0]; hitWay = i[1:0]; vpage = 19'h3C3C3 + i; accType = i[1:0]; pid = 8'(i * 37);
    end
    @(negedge clk);
    chk("R8 sel held", tlbSel, s0);
    chk("R8 cause held", causeReg, c0);
    // the random register was not advanced by idle cycles
    doFault(1'b1, 2'd0, 19'h00010, 2'b00, 8'h01, "R8 lfsr held");
  endtask

  task automatic t_acc_codes();
    doFault(1'b1, 2'd0, 19'h11111, 2'b00, 8'hA0, "R9 read");
    chk("R9 read code", {30'd0, causeReg[9:8]}, 32'd0);
    doFault(1'b0, 2'd2, 19'h22222, 2'b01, 8'hA1, "R9 write");
    chk("R9 write code", {30'd0, causeReg[9:8]}, 32'd1);
    doFault(1'b1, 2'd0, 19'h33333, 2'b10, 8'hA2, "R9 exec");
    chk("R9 exec code", {30'd0, causeReg[9:8]}, 32'd2);
    chk("R7 reserved bits zero", {29'd0, causeReg[12:10]}, 32'd0);
  endtask

  // back-to-back miss strobes: way checked every cycle against the model (R2, R3, R10)
  task automatic t_long_run();
    int bad = 0;
    @(negedge clk);
    faultStb = 1'b1; faultIsMiss = 1'b1; accType = 2'b00;
    for (int i = 0; i < 1100; i++) begin
      logic [1:0] expWay;
      expWay = refLfsr[1:0];
      vpage = 19'(i * 7);
      @(negedge clk);
      refLfsr = stepRef(refLfsr);
      if (tlbSel[5:4] !== expWay) bad++;
      if (refLfsr == 16'h0) bad++;
    end
    faultStb = 1'b0;
    chk("R10 R2 R3 1100-step way sequence mismatches", bad, 0);
    doFault(1'b1, 2'd0, 19'h0000F, 2'b10, 8'h3E, "R10 after long run");
  endtask

  initial begin
    refLfsr = 16'hCCCC;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_patterns();
    t_prot_fault();
    t_idle_hold();
    t_acc_codes();
    t_long_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule